// File: doc/BRIEF.md
# One-Bit Shift and Rotate Unit with Carry Flag

This block performs a single-position shift or rotate on a data word and
produces an updated one-bit carry flag alongside the result. A caller presents
the word, the flag value it currently holds, and a three-bit operation select.
One registered stage later the shifted word and the new flag appear at the
output. In every operation the bit pushed off the end of the word becomes the
new flag. The two carry rotates treat the flag as an extra bit of the rotation: the old flag enters the vacated end, and the bit that leaves becomes the new flag.

The input and output are valid/ready streams with one output register between
them. An operation is accepted on a clock edge where `in_valid` and `in_ready`
are both high. `in_ready` is high whenever the output register is empty or is
being drained in the same cycle, so back-to-back operations run at one per
cycle while the consumer keeps `out_ready` high. When the consumer stalls, the
held result and flag stay unchanged and no new operation is taken. Every flag
value is computed only from the operand and flag presented with the accepted
operation, never from a value the block updates in the same cycle.

Top module: `shift1_unit`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is all zeros and `out_t` is 0.
- R2: Select 0 (rotate left): result bit 0 and the new flag both equal the operand's top bit; the other bits move up by one place.
- R3: Select 1 (rotate right): result top bit and the new flag both equal the operand's bit 0; the other bits move down by one place.
- R4: Select 2 (carry rotate left): the word moves up by one, bit 0 takes the presented flag, and the new flag is the operand's top bit.
- R5: Select 3 (carry rotate right): the word moves down by one, the top bit takes the presented flag, and the new flag is the operand's bit 0.
- R6: Selects 4 and 5 (logical and arithmetic shift left) behave identically: the word moves up by one, bit 0 becomes 0, and the new flag is the operand's top bit.
- R7: Select 6 (logical shift right): the word moves down by one, the top bit becomes 0, and the new flag is the operand's bit 0.
- R8: Select 7 (arithmetic shift right): the word moves down by one, the top bit keeps the operand's top bit, and the new flag is the operand's bit 0.
- R9: An operation accepted on a clock edge has its result and flag on `out_data`/`out_t`, with `out_valid` high, right after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_t` hold, and `in_ready` is low.
- R11: On an edge with no accepted operation, `out_data` and `out_t` keep their values; `out_valid` falls if the held result was taken on that edge.
- R12: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The block takes the presented operation on this edge |
| in_data | input | W | Operand word |
| in_t | input | 1 | Current carry flag |
| in_op | input | 3 | Operation select, encoding given in R2 to R8 |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the held result |
| out_data | output | W | Shifted or rotated word |
| out_t | output | 1 | New carry flag |

## Verification
A wrong select decode or a bad fill bit shows on `out_data` or `out_t` one
cycle after the faulty operation is accepted. The carry rotates are run with
both flag values so that a flag taken from the wrong source appears on the
first such operation. A fault in the output register control shows as a result
that changes during a stall, a lost or repeated result, or an `in_ready` that
does not follow `out_ready`. Each of these is visible on the first cycle it
occurs, and the random back-pressure in the bench triggers stalls often.

// File: rtl/shift1_pkg.sv
package shift1_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ROTL  = 3'd0,
    OP_ROTR  = 3'd1,
    OP_ROTCL = 3'd2,
    OP_ROTCR = 3'd3,
    OP_SHLL  = 3'd4,
    OP_SHAL  = 3'd5,
    OP_SHLR  = 3'd6,
    OP_SHAR  = 3'd7
  } shift_op_e;
endpackage

// File: rtl/shift1_core.sv
module shift1_core
  import shift1_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd,
  input  logic         t_prev,
  input  shift_op_e    op,
  output logic [W-1:0] res,
  output logic         t_next
);
  localparam int MSB = W - 1;

  logic to_left;
  logic fill;

  // Direction and the bit entering the vacated end (R2..R8).
  always_comb begin
    unique case (op)
      OP_ROTL:  begin to_left = 1'b1; fill = opnd[MSB]; end
      OP_ROTR:  begin to_left = 1'b0; fill = opnd[0];   end
      OP_ROTCL: begin to_left = 1'b1; fill = t_prev;    end
      OP_ROTCR: begin to_left = 1'b0; fill = t_prev;    end
      OP_SHLL,
      OP_SHAL:  begin to_left = 1'b1; fill = 1'b0;      end
      OP_SHLR:  begin to_left = 1'b0; fill = 1'b0;      end
      OP_SHAR:  begin to_left = 1'b0; fill = opnd[MSB]; end
      default:  begin to_left = 1'b1; fill = 1'b0;      end
    endcase
  end

  // The bit leaving the word always becomes the flag.
  always_comb begin
    if (to_left) begin
      res    = {opnd[MSB-1:0], fill};
      t_next = opnd[MSB];
    end else begin
      res    = {fill, opnd[MSB:1]};
      t_next = opnd[0];
    end
  end
endmodule

// File: rtl/shift1_stage.sv
module shift1_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d_in,
  input  logic         t_in,
  output logic         vld,
  output logic [W-1:0] d_q,
  output logic         t_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      d_q <= '0;
      t_q <= 1'b0;
    end else if (load) begin
      vld <= 1'b1;
      d_q <= d_in;
      t_q <= t_in;
    end else if (drain) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/shift1_unit.sv
module shift1_unit
  import shift1_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_t,
  input  logic [2:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_t
);
  logic [W-1:0] core_res;
  logic         core_t;
  logic         accept;
  shift_op_e    op_sel;

  assign op_sel   = shift_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  shift1_core #(.W(W)) u_core (
    .opnd   (in_data),
    .t_prev (in_t),
    .op     (op_sel),
    .res    (core_res),
    .t_next (core_t)
  );

  shift1_stage #(.W(W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .drain (out_ready),
    .d_in  (core_res),
    .t_in  (core_t),
    .vld   (out_valid),
    .d_q   (out_data),
    .t_q   (out_t)
  );
endmodule

// File: rtl/shift1_unit_chk.sv
module shift1_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         in_t,
  input logic [2:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_t
);
  logic take;
  assign take = in_valid && in_ready;

  p_rotl_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd0 |=> out_data[0] == $past(in_data[W-1]) && out_t == $past(in_data[W-1]));

  p_rotcl_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd2 |=> out_data[0] == $past(in_t) && out_t == $past(in_data[W-1]));

  p_shar_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd7 |=> out_data[W-1] == $past(in_data[W-1]) && out_t == $past(in_data[0]));

  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_t));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(out_data) && $stable(out_t));

  p_drain_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take && out_ready |=> !out_valid);
endmodule

bind shift1_unit shift1_unit_chk #(.W(W)) u_chk (.*);

// File: tb/shift1_unit_bench.sv
module shift1_unit_bench;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM = 3000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         in_t = 1'b0;
  logic [2:0]   in_op = 3'd0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic         out_t;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic         m_vld = 1'b0;
  logic [W-1:0] m_data = '0;
  logic         m_t = 1'b0;
  string        m_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  shift1_unit #(.W(W)) u_shift1_unit (.*);

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [W:0] ref_op(input logic [2:0] op, input logic [W-1:0] d,
                                        input logic t);
    logic [W-1:0] r;
    logic nt;
    r = '0;
    nt = 1'b0;
    for (int i = 0; i < W; i++) begin
      case (op)
        3'd0, 3'd2, 3'd4, 3'd5: r[i] = (i == 0) ? 1'b0 : d[i-1];
        default:                r[i] = (i == W-1) ? 1'b0 : d[i+1];
      endcase
    end
    case (op)
      3'd0: begin r[0] = d[W-1];   nt = d[W-1]; end
      3'd1: begin r[W-1] = d[0];   nt = d[0];   end
      3'd2: begin r[0] = t;        nt = d[W-1]; end
      3'd3: begin r[W-1] = t;      nt = d[0];   end
      3'd4, 3'd5: nt = d[W-1];
      3'd6: nt = d[0];
      default: begin r[W-1] = d[W-1]; nt = d[0]; end
    endcase
    return {nt, r};
  endfunction

  task automatic check(input string req, input string what, input logic [W:0] act,
                       input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at the falling edge: compare outputs, apply new inputs, advance model.
  task automatic step(input logic v, input logic [W-1:0] d, input logic t,
                      input logic [2:0] op, input logic rdy);
    logic [W:0] nx;
    check("R9", "out_valid", {{W{1'b0}}, out_valid}, {{W{1'b0}}, m_vld});
    check(m_req, "data/flag", {out_t, out_data}, {m_t, m_data});
    in_valid = v; in_data = d; in_t = t; in_op = op; out_ready = rdy;
    #1;
    check(m_vld && !rdy ? "R10" : "R12", "in_ready", {{W{1'b0}}, in_ready},
          {{W{1'b0}}, (!m_vld || rdy)});
    if (v && (!m_vld || rdy)) begin
      nx = ref_op(op, d, t);
      m_data = nx[W-1:0];
      m_t = nx[W];
      m_vld = 1'b1;
      m_req = req_of(op);
    end else begin
      if (rdy) m_vld = 1'b0;
      m_req = m_vld ? "R10" : "R11";
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    check("R1", "reset outputs", {out_t, out_data}, '0);
    check("R1", "reset valid", {{W{1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners for every select, both flag values.
    for (int op = 0; op < 8; op++) begin
      step(1'b1, 32'h8000_0001, 1'b0, op[2:0], 1'b1);
      step(1'b1, 32'h7FFF_FFFE, 1'b1, op[2:0], 1'b1);
      step(1'b1, 32'hFFFF_FFFF, 1'b0, op[2:0], 1'b1);
      step(1'b1, 32'h0000_0000, 1'b1, op[2:0], 1'b1);
    end
    // Stall with a held result, then idle cycles (R10, R11).
    step(1'b1, 32'hA5A5_A5A5, 1'b1, 3'd3, 1'b1);
    step(1'b1, 32'h1234_5678, 1'b0, 3'd0, 1'b0);
    step(1'b1, 32'h1111_1111, 1'b1, 3'd7, 1'b0);
    step(1'b0, 32'hDEAD_BEEF, 1'b1, 3'd1, 1'b1);
    step(1'b0, 32'hCAFE_F00D, 1'b0, 3'd2, 1'b0);
    step(1'b0, 32'h0, 1'b0, 3'd0, 1'b1);
    for (int i = 0; i < N_RANDOM; i++) begin
      step(($urandom % 4) != 0, $urandom, $urandom % 2, 3'($urandom % 8),
           ($urandom % 3) != 0);
    end
    step(1'b0, 32'h0, 1'b0, 3'd0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule